// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through a single write-only control word. The word carries an enable bit and a key field. While the watchdog is armed, only a write whose key is the bitwise complement of the stored key counts as service. With enable set, that write restarts the timeout. With enable clear, it disarms the watchdog. Any other write to an armed watchdog just loads a new key and does not reset the timer.

The timeout has two stages. If no service arrives within the first window, counted from the last start or restart, the block raises a non-maskable interrupt request. If a second, shorter window then passes without service, it raises a chip reset request. Both windows are parameters given in clock cycles. The reset request is meant to be consumed by the chip's reset sequencer.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_ni` is asserted, the watchdog is disarmed and both `nmi_req_o` and `chip_rst_req_o` are low.
- R2: While disarmed, a write with `wr_enable_i`=0 has no effect for any key: no request is ever raised afterwards.
- R3: While disarmed, a write with `wr_enable_i`=1 arms the watchdog and stores `wr_key_i`. `nmi_req_o` goes high exactly `NMI_CYCLES` clock edges after the write's edge.
- R4: While armed, a write with `wr_enable_i`=1 whose key equals the bitwise NOT of the stored key restarts the first window from the write's edge. The written key becomes the stored key.
- R5: While armed, a write with `wr_enable_i`=0 whose key equals the bitwise NOT of the stored key disarms the watchdog, and no request follows.
- R6: While armed, a write whose key is not the bitwise NOT of the stored key replaces the stored key and leaves the timeout running unchanged, for either value of the enable bit. Service must then use the NOT of the new key.
- R7: `nmi_req_o` stays high until a restart or a stop. It is low from the edge of the servicing write onward, and both stage counters are reloaded at that same edge.
- R8: If no service arrives, `chip_rst_req_o` goes high exactly `RST_CYCLES` edges after `nmi_req_o` rose. It stays high until `rst_ni`, even if a service write follows.
- R9: A restart issued after `nmi_req_o` has risen, but before the reset window ends, prevents `chip_rst_req_o`.
- R10: The key field is `KEY_W` bits wide (3 by default). Its inverse is the bitwise NOT over all `KEY_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe, one cycle per write |
| wr_enable_i | input | 1 | Enable bit of the written word |
| wr_key_i | input | KEY_W | Key field of the written word |
| nmi_req_o | output | 1 | Non-maskable interrupt request, first stage |
| chip_rst_req_o | output | 1 | Chip reset request, second stage |

## Verification
Each write takes effect at the clock edge that samples the strobe. After a start or a restart, the interrupt is due exactly `NMI_CYCLES` edges after that write edge, and the reset request exactly `RST_CYCLES` edges after the interrupt. A service write must clear the interrupt at its own edge. The bench drives and samples one time unit after each rising edge. Around every due edge it checks the output twice: once just after the preceding edge, where the output must still be low, and once just after the due edge, where it must be high. This pins down the exact cycle count. The sweep covers every start key, every written key and both enable values, so matching and non-matching keys are both exercised.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {WDG_OFF = 1'b0, WDG_ARMED = 1'b1} wdg_state_e;
endpackage

// File: rtl/wdg_key_ctrl.sv
module wdg_key_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned KEY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_enable_i,
  input  logic [KEY_W-1:0] wr_key_i,
  output logic             armed_o,
  output logic             kick_o
);
  wdg_state_e       state_q, state_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             inv_match;

  assign inv_match = (wr_key_i == ~key_q);

  always_comb begin
    state_d = state_q;
    key_d   = key_q;
    kick_o  = 1'b0;
    if (wr_en_i) begin
      if (state_q == WDG_OFF) begin
        if (wr_enable_i) begin
          state_d = WDG_ARMED;
          key_d   = wr_key_i;
          kick_o  = 1'b1;
        end
      end else begin
        key_d = wr_key_i;  // both service and re-key store the written key
        if (inv_match) begin
          kick_o  = 1'b1;
          state_d = wr_enable_i ? WDG_ARMED : WDG_OFF;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WDG_OFF;
      key_q   <= '0;
    end else begin
      state_q <= state_d;
      key_q   <= key_d;
    end
  end

  assign armed_o = (state_q == WDG_ARMED);

  p_off_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDG_OFF && wr_en_i && !wr_enable_i) |=> (state_q == WDG_OFF));
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDG_OFF && wr_en_i && wr_enable_i) |=>
      (state_q == WDG_ARMED && key_q == $past(wr_key_i)));
  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDG_ARMED && wr_en_i && !wr_enable_i && wr_key_i == ~key_q) |=>
      (state_q == WDG_OFF));
  p_rekey_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDG_ARMED && wr_en_i && wr_key_i != ~key_q) |=>
      (state_q == WDG_ARMED && key_q == $past(wr_key_i)));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned NMI_CYCLES = 5_000_000,
  parameter int unsigned RST_CYCLES = 165_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic kick_i,
  output logic nmi_o,
  output logic rst_req_o
);
  localparam int unsigned MAX_CYC = (NMI_CYCLES > RST_CYCLES) ? NMI_CYCLES : RST_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] NMI_LAST = CNT_W'(NMI_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             nmi_q, rst_q;

  // nmi_q doubles as the stage flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      nmi_q <= 1'b0;
    end else if (armed_i && !rst_q) begin
      if (!nmi_q) begin
        if (cnt_q == NMI_LAST) begin
          nmi_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == RST_LAST) begin
        rst_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_q;

  p_kick_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (!nmi_q && cnt_q == '0));
  p_nmi_needs_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_q) |-> $past(armed_i));
  p_rst_after_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(nmi_q));
  p_rst_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int unsigned KEY_W      = 3,
  parameter int unsigned NMI_CYCLES = 5_000_000,
  parameter int unsigned RST_CYCLES = 165_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_enable_i,
  input  logic [KEY_W-1:0] wr_key_i,
  output logic             nmi_req_o,
  output logic             chip_rst_req_o
);
  logic armed, kick;

  wdg_key_ctrl #(.KEY_W(KEY_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_enable_i (wr_enable_i),
    .wr_key_i    (wr_key_i),
    .armed_o     (armed),
    .kick_o      (kick)
  );

  wdg_timer #(.NMI_CYCLES(NMI_CYCLES), .RST_CYCLES(RST_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .armed_i   (armed),
    .kick_i    (kick),
    .nmi_o     (nmi_req_o),
    .rst_req_o (chip_rst_req_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_rst_req_o) |-> nmi_req_o);
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KW   = 3;
  localparam int NMI  = 8;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_enable = 1'b0;
  logic [KW-1:0] wr_key = '0;
  logic nmi, crst;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.KEY_W(KW), .NMI_CYCLES(NMI), .RST_CYCLES(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_enable_i(wr_enable),
    .wr_key_i(wr_key), .nmi_req_o(nmi), .chip_rst_req_o(crst)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  // the write takes effect at the next rising edge; returns 1 unit after it
  task automatic wr(input logic en, input logic [KW-1:0] key);
    wr_en = 1'b1; wr_enable = en; wr_key = key;
    tick(1);
    wr_en = 1'b0; wr_enable = 1'b0; wr_key = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    chk("R1 nmi after reset", nmi, 1'b0);
    chk("R1 crst after reset", crst, 1'b0);

    // R2: writes while disarmed with enable clear do nothing, any key
    for (int k = 0; k < (1 << KW); k++) wr(1'b0, KW'(k));
    tick(NMI + RSTC + 2);
    chk("R2 nmi stays low", nmi, 1'b0);
    chk("R2 crst stays low", crst, 1'b0);

    // R8: unserviced path to chip reset, sticky through a later service
    do_reset();
    wr(1'b1, 3'b101);
    tick(NMI - 1);
    chk("R3 nmi not yet", nmi, 1'b0);
    tick(1);
    chk("R3 nmi due", nmi, 1'b1);
    tick(RSTC - 1);
    chk("R8 crst not yet", crst, 1'b0);
    chk("R7 nmi held", nmi, 1'b1);
    tick(1);
    chk("R8 crst due", crst, 1'b1);
    wr(1'b1, 3'b010);
    chk("R7 nmi cleared by service", nmi, 1'b0);
    tick(NMI + 2);
    chk("R8 crst sticky", crst, 1'b1);
    do_reset();
    chk("R1 crst cleared by reset", crst, 1'b0);

    // sweep: start key k, then write (e, s) d edges later
    for (int k = 0; k < (1 << KW); k++)
      for (int s = 0; s < (1 << KW); s++)
        for (int e = 0; e < 2; e++) begin
          int d;
          logic [KW-1:0] kk, ss;
          kk = KW'(k); ss = KW'(s);
          d = ((k + s) % 3) + 1;
          do_reset();
          wr(1'b1, kk);
          tick(d - 1);
          wr(e[0], ss);
          if (ss == ~kk) begin  // R10 inverse over all key bits
            if (e[0]) begin
              tick(NMI - 1);
              chk("R4 restarted, nmi not yet", nmi, 1'b0);
              tick(1);
              chk("R4 nmi after restart", nmi, 1'b1);
            end else begin
              tick(NMI + RSTC + 2);
              chk("R5 stopped, no nmi", nmi, 1'b0);
              chk("R5 stopped, no crst", crst, 1'b0);
            end
          end else begin
            tick(NMI - d - 1);
            chk("R6 rekey keeps timer, nmi not yet", nmi, 1'b0);
            tick(1);
            chk("R6 rekey keeps timer, nmi due", nmi, 1'b1);
            wr(1'b1, ~ss);
            chk("R7 nmi cleared at service edge", nmi, 1'b0);
            tick(RSTC + 2);
            chk("R9 no crst after late restart", crst, 1'b0);
            chk("R9 nmi low after restart", nmi, 1'b0);
          end
        end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule